// File: doc/BRIEF.md
# General-Purpose I/O Port with Set/Clear/Toggle Aliases

A memory-mapped port of up to 32 pins on a plain 32-bit register bus: byte address, write strobe, write data and combinational read data. Software drives pins through an output register and a direction register, and reads the pins through a synchronized data register. The output, direction and interrupt-enable registers each have three extra write addresses that OR, AND or XOR the written word into the register in one bus cycle. Several agents can therefore change separate bits without a read-modify-write race.

Every interrupt-capable pin has a detector that works in level or edge mode, with a polarity bit for each pin. A detector event sets a sticky pending flag. Software clears a flag by writing 1 to its bit. A byte-per-pin routing table steers each flag onto one of a small number of interrupt lines. A read-only capability word reports the pin count, the line count and whether the routing table is active. Software can find which pins can raise interrupts by writing all ones to the polarity register and reading it back.

Address map: 0x00 data, 0x04 output, 0x08 direction, 0x0C enable, 0x10 polarity, 0x14 edge select, 0x18 capability, 0x20 flags, 0x40–0x5C routing table. Alias blocks: base+0x80 OR, base+0xA0 AND, base+0xC0 XOR.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset the output, direction, enable, polarity, edge, flag and routing registers read 0, pin_oe_o is 0 (all pins inputs) and irq_o is 0.
- R2: A write to 0x04, 0x08, 0x0C or 0x14 loads the register, and a read at the same address returns it. pin_o equals the output register, and pin_oe_o equals the direction register, where 1 makes a pin an output.
- R3: A write to 0x84, 0x88 or 0x8C makes the output, direction or enable register equal to its old value OR the write data.
- R4: A write to 0xA4, 0xA8 or 0xAC makes the same registers equal to their old value AND the write data.
- R5: A write to 0xC4, 0xC8 or 0xCC XORs the write data into the same registers. A read at any alias address returns the underlying register.
- R6: Reading 0x00 returns pin_i as it stood two clock edges earlier, after a two-flop synchronizer. After only one edge the old value is still returned.
- R7: When the edge bit is 0 (level mode), a pin with polarity 1 sets its flag while it is high, and a pin with polarity 0 sets its flag while it is low.
- R8: When the edge bit is 1, a pin with polarity 1 sets its flag on a rising edge only, and a pin with polarity 0 on a falling edge only. A steady level sets nothing.
- R9: A flag is never set while its enable bit (0x0C) is 0.
- R10: Flags at 0x20 are sticky. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R11: If a detector event and a clear write hit the same flag in the same cycle, the flag stays set.
- R12: The polarity bits of pins outside the IRQ_CAP mask read 0 whatever is written, and those pins never set a flag. With the default mask, writing 0xFFFFFFFF to 0x10 reads back 0x00FFFFFF.
- R13: Routing word 0x40+4k holds pin 4k in bits [31:24], pin 4k+1 in [23:16], pin 4k+2 in [15:8] and pin 4k+3 in [7:0]. irq_o[l] is the OR of the flags whose entry equals l. An entry of NLINES or more routes the pin to no line.
- R14: Capability word 0x18 is read-only. Bits [4:0] hold NPIN-1, bits [9:8] hold the routing mode (1 = table used, 0 = pin p fixed to line p mod NLINES) and bits [15:12] hold NLINES-1. The default is 0x0000311F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NPIN | Pin levels from the pads, asynchronous |
| pin_o | output | NPIN | Output levels to the pads |
| pin_oe_o | output | NPIN | Output enables, 1 = drive |
| irq_o | output | NLINES | Interrupt lines |

## Verification
A wrong alias operation or a bad register write shows up on pin_o or pin_oe_o right after the write edge, and on the next read of any alias of that register. A synchronizer with the wrong depth makes the data read differ exactly one edge early or late. A wrong detector, enable gate or clear priority leaves a flag bit wrong in the 0x20 read made three edges after the pin moves, and leaves irq_o wrong in that same cycle. A routing-table fault moves a pending flag onto a different irq_o bit as soon as the table write lands.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam logic [4:0] OFF_DATA = 5'h00;
  localparam logic [4:0] OFF_OUT  = 5'h04;
  localparam logic [4:0] OFF_DIR  = 5'h08;
  localparam logic [4:0] OFF_EN   = 5'h0C;
  localparam logic [4:0] OFF_POL  = 5'h10;
  localparam logic [4:0] OFF_EDGE = 5'h14;
  localparam logic [4:0] OFF_CAP  = 5'h18;

  // address bits [7:5] select the register group
  localparam logic [2:0] GRP_BASE = 3'b000;
  localparam logic [2:0] GRP_FLAG = 3'b001;
  localparam logic [2:0] GRP_MAP  = 3'b010;
  localparam logic [2:0] GRP_OR   = 3'b100;
  localparam logic [2:0] GRP_AND  = 3'b101;
  localparam logic [2:0] GRP_XOR  = 3'b110;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_FLIP = 2'd3
  } alias_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      unique case (op_i)
        OP_LOAD: q <= wdata_i;
        OP_SET:  q <= q | wdata_i;
        OP_CLR:  q <= q & wdata_i;
        OP_FLIP: q <= q ^ wdata_i;
        default: q <= q;
      endcase
    end
  end

  assign q_o = q;

  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  a_r4_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_CLR) |=> ((q_o & ~$past(wdata_i)) == '0));
  a_r5_flip_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_FLIP) |=> (q_o == ($past(q_o) ^ $past(wdata_i))));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int unsigned       NPIN = 32,
  parameter logic [NPIN-1:0]   CAP  = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] en_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] edge_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] flag_o
);
  logic [NPIN-1:0] prev_q, flag_q;
  logic [NPIN-1:0] rise_w, fall_w, lvl_hit_w, edge_hit_w, set_w;

  assign rise_w     = lvl_i & ~prev_q;
  assign fall_w     = ~lvl_i & prev_q;
  assign lvl_hit_w  = (pol_i & lvl_i) | (~pol_i & ~lvl_i);
  assign edge_hit_w = (pol_i & rise_w) | (~pol_i & fall_w);
  assign set_w      = ((edge_i & edge_hit_w) | (~edge_i & lvl_hit_w)) & en_i & CAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // set dominates a same-cycle clear
      flag_q <= set_w | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  a_r9_no_flag_unenabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(en_i)) == '0));
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_o) & ~$past(clr_i) & ~flag_o) == '0));
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_w) & ~flag_o) == '0));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_i) & ~$past(set_w) & flag_o) == '0));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned NLINES = 4,
  parameter bit          MAP_EN = 1'b1
) (
  input  logic [NPIN-1:0]      flag_i,
  input  logic [NPIN-1:0][7:0] map_i,
  output logic [NLINES-1:0]    line_o
);
  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [NPIN-1:0] hit;
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      if (MAP_EN) begin : g_tab
        assign hit[p] = flag_i[p] && (map_i[p] == 8'(l));
      end else begin : g_fix
        assign hit[p] = flag_i[p] && ((p % NLINES) == l);
      end
    end
    assign line_o[l] = |hit;
  end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NPIN    = 32,
  parameter int unsigned NLINES  = 4,
  parameter bit          MAP_EN  = 1'b1,
  parameter logic [31:0] IRQ_CAP = 32'h00FF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [NLINES-1:0] irq_o
);
  localparam int unsigned     MAP_WORDS = (NPIN + 3) / 4;
  localparam logic [NPIN-1:0] CAP_MASK  = IRQ_CAP[NPIN-1:0];
  localparam logic [31:0]     CAP_WORD  = {16'h0, 4'(NLINES - 1), 2'b00, 2'(MAP_EN),
                                           3'b000, 5'(NPIN - 1)};

  logic [2:0] grp;
  logic [4:0] sub;
  logic       reg_grp;
  alias_op_e  op_w;
  logic       out_wr, dir_wr, en_wr, pol_wr, edge_wr, map_wr;
  logic [NPIN-1:0] clr_w;

  logic [NPIN-1:0]      data_w, out_q, dir_q, en_q, flag_w;
  logic [NPIN-1:0]      pol_q, edge_q;
  logic [NPIN-1:0][7:0] map_q;

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  assign grp     = addr_i[7:5];
  assign sub     = addr_i[4:0];
  assign reg_grp = (grp == GRP_BASE) || (grp == GRP_OR) || (grp == GRP_AND) || (grp == GRP_XOR);

  always_comb begin
    unique case (grp)
      GRP_OR:  op_w = OP_SET;
      GRP_AND: op_w = OP_CLR;
      GRP_XOR: op_w = OP_FLIP;
      default: op_w = OP_LOAD;
    endcase
  end

  assign out_wr  = we_i && reg_grp && (sub == OFF_OUT);
  assign dir_wr  = we_i && reg_grp && (sub == OFF_DIR);
  assign en_wr   = we_i && reg_grp && (sub == OFF_EN);
  assign pol_wr  = we_i && (grp == GRP_BASE) && (sub == OFF_POL);
  assign edge_wr = we_i && (grp == GRP_BASE) && (sub == OFF_EDGE);
  assign map_wr  = MAP_EN && we_i && (grp == GRP_MAP) && (int'(addr_i[4:2]) < MAP_WORDS);
  assign clr_w   = (we_i && (grp == GRP_FLAG) && (sub == 5'h00)) ? wdata_i[NPIN-1:0] : '0;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (data_w)
  );

  gpio_alias_reg #(.W(NPIN)) u_out (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (out_wr), .op_i (op_w),
    .wdata_i (wdata_i[NPIN-1:0]), .q_o (out_q)
  );

  gpio_alias_reg #(.W(NPIN)) u_dir (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (dir_wr), .op_i (op_w),
    .wdata_i (wdata_i[NPIN-1:0]), .q_o (dir_q)
  );

  gpio_alias_reg #(.W(NPIN)) u_en (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (en_wr), .op_i (op_w),
    .wdata_i (wdata_i[NPIN-1:0]), .q_o (en_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      edge_q <= '0;
    end else begin
      if (pol_wr)  pol_q  <= wdata_i[NPIN-1:0] & CAP_MASK;
      if (edge_wr) edge_q <= wdata_i[NPIN-1:0];
    end
  end

  // lower pin index sits in the higher byte of its word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
    end else if (map_wr) begin
      for (int p = 0; p < NPIN; p++) begin
        if (p / 4 == int'(addr_i[4:2])) map_q[p] <= wdata_i[31 - 8 * (p % 4) -: 8];
      end
    end
  end

  gpio_irq_det #(.NPIN(NPIN), .CAP(CAP_MASK)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (data_w),
    .en_i   (en_q),
    .pol_i  (pol_q),
    .edge_i (edge_q),
    .clr_i  (clr_w),
    .flag_o (flag_w)
  );

  gpio_irq_route #(.NPIN(NPIN), .NLINES(NLINES), .MAP_EN(MAP_EN)) u_route (
    .flag_i (flag_w),
    .map_i  (map_q),
    .line_o (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (reg_grp) begin
      unique case (sub)
        OFF_DATA: rdata_o = 32'(data_w);
        OFF_OUT:  rdata_o = 32'(out_q);
        OFF_DIR:  rdata_o = 32'(dir_q);
        OFF_EN:   rdata_o = 32'(en_q);
        OFF_POL:  rdata_o = 32'(pol_q);
        OFF_EDGE: rdata_o = 32'(edge_q);
        OFF_CAP:  rdata_o = CAP_WORD;
        default:  rdata_o = '0;
      endcase
    end else if (grp == GRP_FLAG && sub == 5'h00) begin
      rdata_o = 32'(flag_w);
    end else if (grp == GRP_MAP && MAP_EN) begin
      for (int p = 0; p < NPIN; p++) begin
        if (p / 4 == int'(addr_i[4:2])) rdata_o[31 - 8 * (p % 4) -: 8] = map_q[p];
      end
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  a_r6_two_stage_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (data_w == $past(pin_i, 2)));
  a_r13_line_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (flag_w != '0));
  a_r12_pol_capable_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_wr |=> ((pol_q & ~CAP_MASK) == '0));
endmodule

// File: tb/gpio_alias_port_tb.sv
module gpio_alias_port_tb;
  localparam int NPIN = 32;
  localparam int NL   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;
  logic [NL-1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_alias_port u_dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .pin_i (pin_in),
    .pin_o (pin_out), .pin_oe_o (pin_oe), .irq_o (irq)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 32'hF0F0_1234, 8'h04, 32'hF0F0_1234, "R2"},
    '{8'h84, 32'h0000_000F, 8'h04, 32'hF0F0_123F, "R3"},
    '{8'hA4, 32'hFFFF_00FF, 8'hC4, 32'hF0F0_003F, "R4"},
    '{8'hC4, 32'hFF00_0001, 8'h04, 32'h0FF0_003E, "R5"},
    '{8'h88, 32'h0000_0F00, 8'h08, 32'h0000_0F00, "R3"},
    '{8'hC8, 32'h0000_FF00, 8'h08, 32'h0000_F000, "R5"},
    '{8'hA8, 32'hFFFF_7FFF, 8'hA8, 32'h0000_7000, "R4"},
    '{8'h8C, 32'h0000_0003, 8'h0C, 32'h0000_0003, "R3"},
    '{8'hCC, 32'h0000_0006, 8'h0C, 32'h0000_0005, "R5"},
    '{8'hAC, 32'hFFFF_FFFE, 8'h0C, 32'h0000_0004, "R4"},
    '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'h00FF_FFFF, "R12"},
    '{8'h14, 32'h1234_5678, 8'h14, 32'h1234_5678, "R2"},
    '{8'h40, 32'h0102_0300, 8'h40, 32'h0102_0300, "R13"},
    '{8'h18, 32'hFFFF_FFFF, 8'h18, 32'h0000_311F, "R14"},
    '{8'h5C, 32'h0A0B_0C0D, 8'h5C, 32'h0A0B_0C0D, "R13"}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; pin_in = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(8'h04, v); check("R1", v, 32'h0);
    rd(8'h08, v); check("R1", v, 32'h0);
    rd(8'h0C, v); check("R1", v, 32'h0);
    rd(8'h10, v); check("R1", v, 32'h0);
    rd(8'h14, v); check("R1", v, 32'h0);
    rd(8'h20, v); check("R1", v, 32'h0);
    rd(8'h40, v); check("R1", v, 32'h0);
    check("R1", 32'(pin_oe), 32'h0);
    check("R1", 32'(irq), 32'h0);

    // register and alias vectors
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, v);
      check($sformatf("%s vec%0d", VECS[i].tag, i), v, VECS[i].exp);
    end
    check("R2 pin_o", 32'(pin_out), 32'h0FF0_003E);
    check("R2 pin_oe_o", 32'(pin_oe), 32'h0000_7000);

    // R6 synchronizer latency
    @(negedge clk);
    addr = 8'h00; pin_in = 32'hA5A5_5A5A;
    @(negedge clk); #1 check("R6 one edge", rdata, 32'h0);
    @(negedge clk); #1 check("R6 two edges", rdata, 32'hA5A5_5A5A);

    // interrupt section from a clean state
    do_reset();
    wr(8'h10, 32'h0000_0005);   // pin0 high, pin1 low, pin2 rising, pin3 falling
    wr(8'h14, 32'h0000_000C);
    wr(8'h40, 32'h0001_0203);   // pin n -> line n
    wr(8'h0C, 32'h0000_000F);
    idle(3);
    rd(8'h20, v); check("R7 low level", v, 32'h2);
    check("R13 line1", 32'(irq), 32'h2);

    pin_in[1] = 1'b1; idle(4);
    wr(8'h20, 32'h2);
    rd(8'h20, v); check("R10 clear", v, 32'h0);
    check("R10 irq idle", 32'(irq), 32'h0);

    pin_in[0] = 1'b1; idle(4);
    rd(8'h20, v); check("R7 high level", v, 32'h1);
    check("R13 line0", 32'(irq), 32'h1);
    pin_in[0] = 1'b0; idle(4);
    rd(8'h20, v); check("R10 sticky", v, 32'h1);
    wr(8'h20, 32'hFFFF_FFFE);
    rd(8'h20, v); check("R10 zero no effect", v, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, v); check("R10 clear one", v, 32'h0);

    pin_in[2] = 1'b1; idle(4);
    rd(8'h20, v); check("R8 rising", v, 32'h4);
    check("R13 line2", 32'(irq), 32'h4);
    wr(8'h20, 32'h4); idle(4);
    rd(8'h20, v); check("R8 steady high", v, 32'h0);
    pin_in[3] = 1'b1; idle(4);
    rd(8'h20, v); check("R8 rise on falling pin", v, 32'h0);
    pin_in[3] = 1'b0; idle(4);
    rd(8'h20, v); check("R8 falling", v, 32'h8);
    check("R13 line3", 32'(irq), 32'h8);
    wr(8'h20, 32'h8);

    // R9: pin0 high-level but disabled, pin4 low-level never enabled
    wr(8'hAC, 32'hFFFF_FFFE);
    pin_in[0] = 1'b1; idle(4);
    rd(8'h20, v); check("R9 disabled", v, 32'h0);

    // R11: level event held during the clear write
    pin_in[1] = 1'b0; idle(4);
    rd(8'h20, v); check("R11 pre", v, 32'h2);
    wr(8'h20, 32'h2);
    rd(8'h20, v); check("R11 set wins", v, 32'h2);
    pin_in[1] = 1'b1; idle(4);
    wr(8'h20, 32'h2);
    rd(8'h20, v); check("R11 released", v, 32'h0);

    // R12: pin30 outside capable set, low level, enabled
    wr(8'h8C, 32'h4000_0000); idle(4);
    rd(8'h20, v); check("R12 incapable pin", v, 32'h0);
    wr(8'hAC, 32'hBFFF_FFFF);

    // R13: out-of-range entry, then reroute
    wr(8'h40, 32'h0007_0203);
    pin_in[1] = 1'b0; idle(4);
    rd(8'h20, v); check("R13 flag present", v, 32'h2);
    check("R13 unrouted", 32'(irq), 32'h0);
    wr(8'h40, 32'h0003_0203);
    #1 check("R13 rerouted", 32'(irq), 32'h8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule